// File: doc/BRIEF.md
# Aligned Flash Erase Range Sequencer

This block turns a request to erase a region of an SPI flash into the series of flash commands that carry it out. The request arrives as one 32-bit range word. The start of the region and its length are both counted in 256-byte pages. The sequencer checks that both ends of the region fall on 4KB boundaries. It then walks the region from low to high addresses. At each step it uses the largest erase size that the current address and the remaining length allow.

Each erase is sent out in the same way. A write-enable command goes first, then the sized erase command. After that, a read-status command opens a status transaction, and status bytes are fetched at a fixed cycle interval until the busy flag clears or a cycle budget runs out. A no-operation command then closes the transaction.

A whole-device erase request uses the same write-enable, busy-wait and close path. Commands go out on a valid/ready handshake to a flash command engine, and status bytes come back on a request/valid pair. The block ends each accepted request with a single-cycle `done` pulse and a result code on `err`.

Top module: `erase_seq`

## Requirements
- R1: The range word gives the start page in bits 31:16 and the length in pages in bits 15:0. The byte address is the page number times 256, and erase commands carry this byte address on `cmd_addr`.
- R2: A range whose start or end (start plus length) is not a multiple of 4096 bytes issues no command. The cycle after acceptance, `done` pulses with `err` = 1.
- R3: At each step a 64KB erase (opcode 0xD8) is used when the current address is a multiple of 64KB and 64KB still fits before the end. Otherwise a 32KB erase (0x52) is used under the same rule for 32KB. Otherwise a 4KB erase (0x20) is used.
- R4: Every erase command, including the whole-device erase, is issued directly after a write-enable command (0x06). Non-erase commands and the whole-device erase carry address 0.
- R5: After each erase, a read-status command (0x05) is issued. Status bytes are then fetched through `sts_req`, each fetch at least POLL_CYC cycles after the previous step. Polling continues while bit 0 (busy) of the byte is 1. Once bit 0 reads 0, a no-operation command (0x00) is issued.
- R6: If bit 0 is still 1 when TIMEOUT_CYC cycles have passed since the read-status command, the no-operation command is still issued. No further erase follows, and `done` pulses with `err` = 2.
- R7: The current address advances by the size of the erase just issued. When it reaches the end, `done` pulses with `err` = 0 right after the closing no-operation command.
- R8: A request with `req_chip` = 1 issues write-enable, whole-device erase (0x60), read-status, busy polling and no-operation, then `done` with `err` = 0.
- R9: A request presented while a sequence is in progress is ignored. It issues no command and produces no `done`.
- R10: An aligned range of zero length issues no command. `done` pulses with `err` = 0 the cycle after acceptance.
- R11: `done` lasts one cycle per completed request. While `cmd_valid` is high and `cmd_ready` is low, `cmd_op` and `cmd_addr` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_chip | input | 1 | 1 selects whole-device erase; `req_range` is then unused |
| req_range | input | 32 | Start page in bits 31:16, page count in bits 15:0 |
| cmd_valid | output | 1 | Command offered to the flash engine |
| cmd_op | output | 8 | Flash opcode |
| cmd_addr | output | 25 | Byte address for sized erases, otherwise 0 |
| cmd_ready | input | 1 | Engine accepts the command this cycle |
| sts_req | output | 1 | Request for one status byte |
| sts_valid | input | 1 | Status byte present |
| sts_data | input | 8 | Status byte; bit 0 is busy |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | 0 success, 1 misaligned range, 2 busy timeout |

## Verification
The bench targets the points where the choice of erase size changes. These are a start just past a 4KB boundary that must climb through 4KB steps and one 32KB step before 64KB steps become possible, and a 64KB-aligned start whose length does not fill 64KB. A design that tests only alignment, or only the remaining length, would issue an oversized erase beyond the end, or far more small erases than needed.

Misaligned starts and misaligned ends are tried separately. A design that checks only one end would start erasing. A busy flag that never clears must still yield the closing no-operation command; a design that skips it leaves the status transaction open.

A request pushed in mid-sequence checks that nothing is restarted and no extra `done` appears. Repeated busy reads under a stalling `cmd_ready` check that status fetches are counted exactly and that commands hold steady while they wait.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

    // range word layout and derived byte address width
    localparam int unsigned PG_FIELD_W = 16;
    localparam int unsigned PG_LG      = 8;
    localparam int unsigned ADDR_W     = PG_FIELD_W + PG_LG + 1;

    localparam int unsigned LG_4K  = 12;
    localparam int unsigned LG_32K = 15;
    localparam int unsigned LG_64K = 16;

    typedef logic [ADDR_W-1:0] addr_t;

    localparam addr_t SZ_4K  = addr_t'(1) << LG_4K;
    localparam addr_t SZ_32K = addr_t'(1) << LG_32K;
    localparam addr_t SZ_64K = addr_t'(1) << LG_64K;

    typedef enum logic [7:0] {
        OP_NOP  = 8'h00,
        OP_RDSR = 8'h05,
        OP_WREN = 8'h06,
        OP_SE4  = 8'h20,
        OP_SE32 = 8'h52,
        OP_CHIP = 8'h60,
        OP_SE64 = 8'hD8
    } op_e;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_ALIGN = 2'd1,
        ERR_TMO   = 2'd2
    } err_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_WREN, ST_ERASE, ST_RDSR, ST_GAP, ST_FETCH, ST_NOP
    } state_e;

    // one erase step: opcode and bytes covered
    typedef struct packed {
        op_e   op;
        addr_t len;
    } step_t;

    function automatic logic aligned(addr_t a, int unsigned lg);
        addr_t m;
        m = (addr_t'(1) << lg) - addr_t'(1);
        return (a & m) == '0;
    endfunction

    function automatic logic is_erase(logic [7:0] op);
        return op == OP_SE4 || op == OP_SE32 || op == OP_SE64 || op == OP_CHIP;
    endfunction

endpackage

// File: rtl/erase_size_pick.sv
module erase_size_pick
    import erase_seq_pkg::*;
(
    input  addr_t cur,
    input  addr_t stop,
    output step_t step
);

    addr_t rem;

    always_comb begin
        rem = stop - cur;
        if (aligned(cur, LG_64K) && rem >= SZ_64K) begin
            step.op  = OP_SE64;
            step.len = SZ_64K;
        end else if (aligned(cur, LG_32K) && rem >= SZ_32K) begin
            step.op  = OP_SE32;
            step.len = SZ_32K;
        end else begin
            step.op  = OP_SE4;
            step.len = SZ_4K;
        end
    end

endmodule

// File: rtl/poll_timer.sv
module poll_timer #(
    parameter int unsigned      POLL_CYC    = 100,
    parameter longint unsigned  TIMEOUT_CYC = 64'd20_000_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic in_gap,
    input  logic in_wait,
    output logic gap_done,
    output logic expired
);

    localparam int unsigned GAP_W  = $clog2(POLL_CYC + 1);
    localparam int unsigned ELAP_W = $clog2(TIMEOUT_CYC + 1);

    logic [GAP_W-1:0]  gap_cnt;
    logic [ELAP_W-1:0] elapsed;

    always_ff @(posedge clk) begin
        if (rst || !in_gap) gap_cnt <= '0;
        else                gap_cnt <= gap_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || restart)          elapsed <= '0;
        else if (in_wait && !expired) elapsed <= elapsed + 1'b1;
    end

    assign gap_done = in_gap && (gap_cnt == GAP_W'(POLL_CYC - 1));
    assign expired  = elapsed >= ELAP_W'(TIMEOUT_CYC);

    // R5
    gap_bound_chk: assert property (@(posedge clk) disable iff (rst)
        in_gap |-> gap_cnt < GAP_W'(POLL_CYC));

endmodule

// File: rtl/erase_seq.sv
module erase_seq
    import erase_seq_pkg::*;
#(
    parameter int unsigned     POLL_CYC    = 100,
    parameter longint unsigned TIMEOUT_CYC = 64'd20_000_000_000
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               req_valid,
    input  logic                               req_chip,
    input  logic [31:0]                        req_range,
    output logic                               cmd_valid,
    output logic [7:0]                         cmd_op,
    output logic [erase_seq_pkg::ADDR_W-1:0]   cmd_addr,
    input  logic                               cmd_ready,
    output logic                               sts_req,
    input  logic                               sts_valid,
    input  logic [7:0]                         sts_data,
    output logic                               done,
    output logic [1:0]                         err
);

    state_e state;
    addr_t  cur, stop, step_len;
    logic   chip_mode, tmo_flag, done_q, last_was_wren;
    err_e   err_q;
    step_t  pick;
    op_e    op_now;
    logic   xfer, gap_done, expired;
    addr_t  start_b, len_b, end_b, next_cur;
    logic   misaligned;

    erase_size_pick u_pick (
        .cur  (cur),
        .stop (stop),
        .step (pick)
    );

    poll_timer #(
        .POLL_CYC    (POLL_CYC),
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .restart  (state == ST_RDSR && xfer),
        .in_gap   (state == ST_GAP),
        .in_wait  (state == ST_GAP || state == ST_FETCH),
        .gap_done (gap_done),
        .expired  (expired)
    );

    // range decode
    assign start_b    = addr_t'(req_range[31:16]) << PG_LG;
    assign len_b      = addr_t'(req_range[15:0]) << PG_LG;
    assign end_b      = start_b + len_b;
    assign misaligned = !aligned(start_b, LG_4K) || !aligned(end_b, LG_4K);
    assign next_cur   = cur + step_len;

    always_comb begin
        unique case (state)
            ST_WREN:  op_now = OP_WREN;
            ST_ERASE: op_now = chip_mode ? OP_CHIP : pick.op;
            ST_RDSR:  op_now = OP_RDSR;
            default:  op_now = OP_NOP;
        endcase
    end

    assign cmd_valid = state == ST_WREN || state == ST_ERASE ||
                       state == ST_RDSR || state == ST_NOP;
    assign cmd_op    = op_now;
    assign cmd_addr  = (state == ST_ERASE && !chip_mode) ? cur : '0;
    assign xfer      = cmd_valid && cmd_ready;
    assign sts_req   = state == ST_FETCH;
    assign done      = done_q;
    assign err       = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cur       <= '0;
            stop      <= '0;
            step_len  <= '0;
            chip_mode <= 1'b0;
            tmo_flag  <= 1'b0;
            done_q    <= 1'b0;
            err_q     <= ERR_NONE;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    tmo_flag <= 1'b0;
                    if (req_chip) begin
                        chip_mode <= 1'b1;
                        state     <= ST_WREN;
                    end else if (misaligned) begin
                        done_q <= 1'b1;
                        err_q  <= ERR_ALIGN;
                    end else if (len_b == '0) begin
                        done_q <= 1'b1;
                        err_q  <= ERR_NONE;
                    end else begin
                        chip_mode <= 1'b0;
                        cur       <= start_b;
                        stop      <= end_b;
                        state     <= ST_WREN;
                    end
                end
                ST_WREN: if (xfer) state <= ST_ERASE;
                ST_ERASE: if (xfer) begin
                    step_len <= pick.len;
                    state    <= ST_RDSR;
                end
                ST_RDSR: if (xfer) state <= ST_GAP;
                ST_GAP:  if (gap_done) state <= ST_FETCH;
                ST_FETCH: if (sts_valid) begin
                    if (!sts_data[0]) begin
                        state <= ST_NOP;
                    end else if (expired) begin
                        tmo_flag <= 1'b1;
                        state    <= ST_NOP;
                    end else begin
                        state <= ST_GAP;
                    end
                end
                ST_NOP: if (xfer) begin
                    cur <= next_cur;
                    if (tmo_flag) begin
                        done_q <= 1'b1;
                        err_q  <= ERR_TMO;
                        state  <= ST_IDLE;
                    end else if (chip_mode || next_cur == stop) begin
                        done_q <= 1'b1;
                        err_q  <= ERR_NONE;
                        state  <= ST_IDLE;
                    end else begin
                        state <= ST_WREN;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // history of the last accepted command, for the ordering check
    always_ff @(posedge clk) begin
        if (rst)       last_was_wren <= 1'b0;
        else if (xfer) last_was_wren <= (cmd_op == OP_WREN);
    end

    // R11
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_addr));

    // R4
    wren_first_chk: assert property (@(posedge clk) disable iff (rst)
        xfer && is_erase(cmd_op) |-> last_was_wren);

    // R3
    big_erase_align_chk: assert property (@(posedge clk) disable iff (rst)
        xfer && cmd_op == OP_SE64 |-> aligned(cmd_addr, LG_64K) && cmd_addr + SZ_64K <= stop);

    // R3
    mid_erase_align_chk: assert property (@(posedge clk) disable iff (rst)
        xfer && cmd_op == OP_SE32 |-> aligned(cmd_addr, LG_32K) && cmd_addr + SZ_32K <= stop);

    // R2
    align_err_prompt_chk: assert property (@(posedge clk) disable iff (rst)
        done && err == ERR_ALIGN |-> $past(state == ST_IDLE && req_valid && !req_chip));

    // R5
    fetch_after_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sts_req) |-> $past(state == ST_GAP));

endmodule

// File: tb/erase_seq_tb.sv
module erase_seq_tb;
    import erase_seq_pkg::*;

    localparam int unsigned POLL = 4;
    localparam int unsigned TMO  = 40;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_chip;
    logic [31:0] req_range;
    logic        cmd_valid;
    logic [7:0]  cmd_op;
    addr_t       cmd_addr;
    logic        cmd_ready;
    logic        sts_req, sts_valid;
    logic [7:0]  sts_data;
    logic        done;
    logic [1:0]  err;

    always #5 clk = ~clk;

    erase_seq #(.POLL_CYC(POLL), .TIMEOUT_CYC(TMO)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_chip(req_chip),
        .req_range(req_range), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_ready(cmd_ready), .sts_req(sts_req),
        .sts_valid(sts_valid), .sts_data(sts_data), .done(done), .err(err)
    );

    typedef struct packed {
        logic [7:0] op;
        addr_t      addr;
    } cmd_rec_t;

    cmd_rec_t   exp_q[$];
    logic [1:0] exp_err_q[$];
    int   total = 0, bad = 0;
    int   busy_cfg = 0, busy_left = 0, reads = 0, dones = 0;
    int   cyc = 0, last_rdsr = 0;
    bit   gap_pending = 0, stall_en = 0;
    string tag = "R1";

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // flash engine model and scoreboard monitor
    always @(negedge clk) begin
        cyc++;
        cmd_ready = stall_en ? cyc[0] : 1'b1;
        if (!rst && cmd_valid && cmd_ready) begin
            if (exp_q.size() == 0) begin
                chk(0, "R9", "unexpected command", cmd_op, 0);
            end else begin
                cmd_rec_t e;
                e = exp_q.pop_front();
                chk(cmd_op == e.op, tag, "command opcode", cmd_op, e.op);
                chk(cmd_addr == e.addr, tag, "command address", cmd_addr, e.addr);
            end
            if (is_erase(cmd_op)) busy_left = busy_cfg;
            if (cmd_op == OP_RDSR) begin
                last_rdsr   = cyc;
                gap_pending = 1;
            end
        end
        if (!rst && sts_req) begin
            sts_valid = 1'b1;
            sts_data  = (busy_left > 0) ? 8'h01 : 8'hFE;
            if (busy_left > 0) busy_left--;
            reads++;
            if (gap_pending) chk(cyc - last_rdsr >= POLL, "R5", "poll spacing",
                                 cyc - last_rdsr, POLL);
            gap_pending = 0;
        end else begin
            sts_valid = 1'b0;
            sts_data  = 8'h00;
        end
        if (!rst && done) begin
            dones++;
            if (exp_err_q.size() == 0) begin
                chk(0, "R9", "unexpected done", err, 0);
            end else begin
                logic [1:0] ee;
                ee = exp_err_q.pop_front();
                chk(err == ee, tag, "result code", err, ee);
            end
        end
    end

    task automatic push_cmd(logic [7:0] op, addr_t a);
        exp_q.push_back({op, a});
    endtask

    // builds the expected command stream from the requirements
    task automatic plan_range(logic [15:0] spg, logic [15:0] lpg, output int n);
        longint s, e, a, sz;
        logic [7:0] op;
        n = 0;
        s = longint'(spg) * 256;
        e = s + longint'(lpg) * 256;
        if ((s % 4096) != 0 || (e % 4096) != 0) begin
            exp_err_q.push_back(2'd1);
            return;
        end
        a = s;
        while (a < e) begin
            if (a % 65536 == 0 && a + 65536 <= e) begin sz = 65536; op = 8'hD8; end
            else if (a % 32768 == 0 && a + 32768 <= e) begin sz = 32768; op = 8'h52; end
            else begin sz = 4096; op = 8'h20; end
            push_cmd(8'h06, '0);
            push_cmd(op, addr_t'(a));
            push_cmd(8'h05, '0);
            push_cmd(8'h00, '0);
            a += sz;
            n++;
        end
        exp_err_q.push_back(2'd0);
    endtask

    task automatic issue(bit chip, logic [15:0] spg, logic [15:0] lpg);
        @(negedge clk);
        req_valid = 1'b1;
        req_chip  = chip;
        req_range = {spg, lpg};
        @(negedge clk);
        req_valid = 1'b0;
        req_chip  = 1'b0;
    endtask

    task automatic wait_done(int target);
        for (int i = 0; i < 5000 && dones < target; i++) @(negedge clk);
        chk(dones >= target, tag, "done seen", dones, target);
    endtask

    task automatic run_range(logic [15:0] spg, logic [15:0] lpg, int busyn, string t);
        int n, r0, d0;
        tag      = t;
        busy_cfg = busyn;
        r0       = reads;
        d0       = dones;
        plan_range(spg, lpg, n);
        issue(0, spg, lpg);
        wait_done(d0 + 1);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, t, "commands left over", exp_q.size(), 0);
        chk(reads - r0 == n * (busyn + 1), "R5", "status reads", reads - r0, n * (busyn + 1));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int d0;
        rst = 1'b1; req_valid = 1'b0; req_chip = 1'b0; req_range = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state, R11
        chk(!cmd_valid && !done && !sts_req, "R11", "idle after reset",
            {cmd_valid, done, sts_req}, 0);

        // R1 R3: single 4KB erase at 0
        run_range(16'h0000, 16'h0010, 0, "R3");
        // R3: two 64KB erases
        run_range(16'h0000, 16'h0200, 0, "R3");
        // R3 R7: climb 4KB steps, one 32KB, then 64KB steps
        run_range(16'h0010, 16'h02F0, 0, "R7");
        // R3: 64KB-aligned start, tail shorter than 64KB
        run_range(16'h0100, 16'h0090, 1, "R3");
        // R1: high start page, end at top of the address space
        run_range(16'hFF00, 16'h0100, 0, "R1");
        // R2: misaligned start, then misaligned end
        run_range(16'h0001, 16'h000F, 0, "R2");
        run_range(16'h0000, 16'h0008, 0, "R2");
        // R10: zero length
        run_range(16'h0020, 16'h0000, 0, "R10");

        // R5 R11: repeated busy reads under a stalling ready
        stall_en = 1;
        run_range(16'h0080, 16'h0020, 3, "R11");
        stall_en = 0;

        // R8: whole-device erase
        tag = "R8";
        busy_cfg = 2;
        d0 = dones;
        push_cmd(8'h06, '0);
        push_cmd(8'h60, '0);
        push_cmd(8'h05, '0);
        push_cmd(8'h00, '0);
        exp_err_q.push_back(2'd0);
        issue(1, 16'h1234, 16'h5678);
        wait_done(d0 + 1);
        chk(exp_q.size() == 0, "R8", "commands left over", exp_q.size(), 0);

        // R6: busy never clears
        tag = "R6";
        busy_cfg = 100000;
        d0 = dones;
        push_cmd(8'h06, '0);
        push_cmd(8'h20, addr_t'(32'h3000));
        push_cmd(8'h05, '0);
        push_cmd(8'h00, '0);
        exp_err_q.push_back(2'd2);
        issue(0, 16'h0030, 16'h0020);
        wait_done(d0 + 1);
        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R6", "commands left over", exp_q.size(), 0);
        chk(dones == d0 + 1, "R6", "done count", dones, d0 + 1);
        busy_cfg = 0;
        busy_left = 0;

        // R9: requests in mid-sequence are ignored
        tag = "R9";
        busy_cfg = 2;
        d0 = dones;
        begin
            int n;
            plan_range(16'h0000, 16'h0020, n);
        end
        issue(0, 16'h0000, 16'h0020);
        repeat (6) @(negedge clk);
        issue(0, 16'h0001, 16'h0003);
        repeat (4) @(negedge clk);
        issue(1, 16'h0000, 16'h0000);
        wait_done(d0 + 1);
        repeat (30) @(negedge clk);
        chk(dones == d0 + 1, "R9", "done count", dones, d0 + 1);
        chk(exp_q.size() == 0, "R9", "commands left over", exp_q.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule